// File: doc/BRIEF.md
# Multi-Channel Interval Timer Array

This block is a bank of independent down-counting timers placed behind a plain memory-mapped register port. Writes take effect at a single clock edge and reads are combinational. Every channel has three registers: a control word, an interval value and a live count. Each channel takes its tick from one of four shared tick-enable inputs and divides that source by a power of two that the channel's own control word selects. A channel that runs down raises its status bit. A shared enable mask passes each status bit to that channel's own interrupt line. A status bit is cleared by writing a one to it.

Each channel is a two-state machine. Its states are `CH_STOPPED` and `CH_RUNNING`, and it has these transitions:
- START: a control write with the enable bit set takes the channel from any state to `CH_RUNNING`.
- HALT: a control write with the enable bit clear takes the channel from any state to `CH_STOPPED`.
- WRAP: a periodic expiry takes `CH_RUNNING` back to `CH_RUNNING` with the interval reloaded.
- SHOT_DONE: a single-shot expiry takes `CH_RUNNING` to `CH_STOPPED` and clears the stored enable bit.

A channel left in `CH_STOPPED` holds its count.

Top module: `itimer_bank`

## Requirements
- R1: After reset every channel's control register reads 0x04 (source 1, divide-by-1, stopped). Interval, count, interrupt enable and interrupt status all read 0, and every interrupt line is low.
- R2: The enable mask sits at offset 0x00 with bit n for channel n. Interrupt line n is high exactly when status bit n and enable bit n are both set.
- R3: The status register sits at 0x04. A write clears each bit where the written value has a one and leaves the other bits alone. An expiry in the same cycle as the write sets its bit anyway.
- R4: A running channel takes one tick for every 2^k edges of source s, where k is control bits [6:4] and s is control bits [3:2]. A control write restarts this division phase.
- R5: A control write with bit 1 (reload) set loads the count from the interval register. The loaded value is the interval as it stood before that edge.
- R6: A control write with bit 0 (enable) set starts the channel. A control write with bit 0 clear stops it, and a stopped channel's count does not change.
- R7: On each tick of a running channel the count drops by one. A tick that finds the count at 1 or 0 is an expiry, and it sets that channel's status bit.
- R8: In periodic mode (control bit 7 = 0), an expiry reloads the count from the interval and the channel keeps running.
- R9: In single-shot mode (control bit 7 = 1), an expiry leaves the count at 0, clears control bit 0 and stops the channel.
- R10: A read of the count register returns the live counter value. A write to it loads the counter. A control or count write in the same cycle as a tick takes priority, and that tick is discarded.
- R11: Channel n (0..5) has its window at 0x10*(n+1), with control at +0x0, interval at +0x4 and count at +0x8. The control register holds bits [7:0]. Every other offset in the 0x400-byte space reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 10 | Byte address, used for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| src_tick | input | 4 | Clock-source tick enables, one per source |
| irq | output | 6 | Interrupt line per channel |

## Verification
A channel whose state machine is out of step with its control word shows up in two ways. A count read returns a frozen or still-moving value in the cycle right after the faulty edge. A stored enable bit that does not match the channel's behaviour shows on the next control read. A prescaler phase fault moves an expiry by whole source ticks. With small intervals, that reaches the status register and the interrupt lines within at most 2^k source edges. The bench therefore samples the addressed register and all interrupt lines after every cycle against a cycle-level reference, so any of these faults is seen within a few cycles of where it starts.

// File: rtl/itb_pkg.sv
package itb_pkg;

    // Control word layout (bit positions are decoded by the channel logic)
    localparam int CTL_W       = 8;
    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_RL_BIT  = 1;
    localparam int SRC_LSB     = 2;
    localparam int SRC_W       = 2;
    localparam int PSC_LSB     = 4;
    localparam int PSC_W       = 3;
    localparam int CTL_MODE_BIT = 7;

    // Prescale phase counter wide enough for the largest divisor
    localparam int PHASE_W     = (1 << PSC_W) - 1;

    // Control value after reset: source 1, divide-by-1, stopped
    localparam logic [CTL_W-1:0] CTL_RESET = 8'h04;

    typedef enum logic {
        CH_STOPPED,
        CH_RUNNING
    } ch_state_e;

    typedef enum logic [2:0] {
        RD_NONE,
        RD_IEN,
        RD_IST,
        RD_CTL,
        RD_IVL,
        RD_CNT
    } rd_kind_e;

endpackage

// File: rtl/itb_decode.sv
module itb_decode
    import itb_pkg::*;
#(
    parameter int NUM_CH   = 6,
    parameter int ADDR_W   = 10,
    parameter int CH_IDX_W = 3
) (
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic                ien_we,
    output logic                ist_we,
    output logic [NUM_CH-1:0]   ctl_we,
    output logic [NUM_CH-1:0]   ivl_we,
    output logic [NUM_CH-1:0]   cnt_we,
    output rd_kind_e            rd_kind,
    output logic [CH_IDX_W-1:0] rd_ch
);

    logic       hi_zero;
    logic [3:0] win;
    logic [3:0] off;
    logic       win_ok;
    logic       glob_ok;

    assign hi_zero = (bus_addr[ADDR_W-1:8] == '0);
    assign win     = bus_addr[7:4];
    assign off     = bus_addr[3:0];
    assign glob_ok = hi_zero && (win == 4'd0);
    assign win_ok  = hi_zero && (win != 4'd0) && (32'(win) <= NUM_CH);

    assign ien_we  = bus_wr && glob_ok && (off == 4'h0);
    assign ist_we  = bus_wr && glob_ok && (off == 4'h4);
    assign rd_ch   = CH_IDX_W'(win - 4'd1);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_we
        logic hit;
        assign hit       = bus_wr && hi_zero && (win == 4'(c + 1));
        assign ctl_we[c] = hit && (off == 4'h0);
        assign ivl_we[c] = hit && (off == 4'h4);
        assign cnt_we[c] = hit && (off == 4'h8);
    end

    always_comb begin
        rd_kind = RD_NONE;
        if (glob_ok) begin
            unique case (off)
                4'h0:    rd_kind = RD_IEN;
                4'h4:    rd_kind = RD_IST;
                default: rd_kind = RD_NONE;
            endcase
        end else if (win_ok) begin
            unique case (off)
                4'h0:    rd_kind = RD_CTL;
                4'h4:    rd_kind = RD_IVL;
                4'h8:    rd_kind = RD_CNT;
                default: rd_kind = RD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/itb_prescaler.sv
module itb_prescaler
    import itb_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SRC_W-1:0]   src_sel,
    input  logic [PSC_W-1:0]   psc_exp,
    output logic               tick
);

    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] mask;
    logic               src_hit;

    assign src_hit = src_tick[src_sel];
    assign mask    = PHASE_W'((32'd1 << psc_exp) - 32'd1);
    assign tick    = run && src_hit && ((phase_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (run && src_hit) begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/itb_channel.sv
module itb_channel
    import itb_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_we,
    input  logic               ivl_we,
    input  logic               cnt_we,
    input  logic [CNT_W-1:0]   wval,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic [CTL_W-1:0]   ctl_q,
    output logic [CNT_W-1:0]   ivl_q,
    output logic [CNT_W-1:0]   cnt_q,
    output logic               expire,
    output logic               running,
    output logic               oneshot
);

    ch_state_e        state_q;
    ch_state_e        state_d;
    logic [CTL_W-1:0] ctl_d;
    logic [CNT_W-1:0] cnt_d;
    logic [CTL_W-1:0] ctl_wval;
    logic             tick;
    logic             at_end;

    assign ctl_wval = wval[CTL_W-1:0];
    assign running  = (state_q == CH_RUNNING);
    assign oneshot  = ctl_q[CTL_MODE_BIT];
    assign at_end   = (cnt_q <= CNT_W'(1));

    itb_prescaler #(
        .NUM_SRC (NUM_SRC)
    ) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .restart  (ctl_we),
        .src_tick (src_tick),
        .src_sel  (ctl_q[SRC_LSB +: SRC_W]),
        .psc_exp  (ctl_q[PSC_LSB +: PSC_W]),
        .tick     (tick)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: START, HALT, WRAP, SHOT_DONE
    always_comb begin
        state_d = state_q;
        if (ctl_we) begin
            state_d = ctl_wval[CTL_EN_BIT] ? CH_RUNNING : CH_STOPPED;
        end else if (!cnt_we) begin
            unique case (state_q)
                CH_RUNNING: begin
                    if (tick && at_end && oneshot) begin
                        state_d = CH_STOPPED;
                    end
                end
                CH_STOPPED: state_d = CH_STOPPED;
                default:    state_d = CH_STOPPED;
            endcase
        end
    end

    // Outputs and datapath next values
    always_comb begin
        ctl_d  = ctl_q;
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (ctl_we) begin
            ctl_d = ctl_wval;
            if (ctl_wval[CTL_RL_BIT]) begin
                cnt_d = ivl_q;
            end
        end else if (cnt_we) begin
            cnt_d = wval;
        end else begin
            unique case (state_q)
                CH_RUNNING: begin
                    if (tick) begin
                        if (at_end) begin
                            expire = 1'b1;
                            if (oneshot) begin
                                cnt_d             = '0;
                                ctl_d[CTL_EN_BIT] = 1'b0;
                            end else begin
                                cnt_d = ivl_q;
                            end
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                end
                CH_STOPPED: cnt_d = cnt_q;
                default:    cnt_d = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
            cnt_q <= '0;
            ivl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            cnt_q <= cnt_d;
            if (ivl_we) begin
                ivl_q <= wval;
            end
        end
    end

endmodule

// File: rtl/itb_irq.sv
module itb_irq #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ien_we,
    input  logic              ist_we,
    input  logic [NUM_CH-1:0] wbits,
    input  logic [NUM_CH-1:0] expire,
    output logic [NUM_CH-1:0] ien_q,
    output logic [NUM_CH-1:0] ist_q,
    output logic [NUM_CH-1:0] irq
);

    logic [NUM_CH-1:0] clr_mask;

    assign clr_mask = ist_we ? wbits : '0;
    assign irq      = ist_q & ien_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= '0;
            ist_q <= '0;
        end else begin
            if (ien_we) begin
                ien_q <= wbits;
            end
            ist_q <= (ist_q & ~clr_mask) | expire;
        end
    end

endmodule

// File: rtl/itimer_bank.sv
module itimer_bank
    import itb_pkg::*;
#(
    parameter int NUM_CH  = 6,
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic [NUM_CH-1:0]  irq
);

    localparam int CNT_W    = DATA_W;
    localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic              ien_we;
    logic              ist_we;
    logic [NUM_CH-1:0] ctl_we;
    logic [NUM_CH-1:0] ivl_we;
    logic [NUM_CH-1:0] cnt_we;
    rd_kind_e          rd_kind;
    logic [CH_IDX_W-1:0] rd_ch;

    logic [NUM_CH-1:0] exp_w;
    logic [NUM_CH-1:0] run_w;
    logic [NUM_CH-1:0] mode_w;
    logic [NUM_CH-1:0] ien_w;
    logic [NUM_CH-1:0] ist_w;

    logic [CTL_W-1:0]  ctl_arr [NUM_CH];
    logic [CNT_W-1:0]  ivl_arr [NUM_CH];
    logic [CNT_W-1:0]  cnt_arr [NUM_CH];

    itb_decode #(
        .NUM_CH   (NUM_CH),
        .ADDR_W   (ADDR_W),
        .CH_IDX_W (CH_IDX_W)
    ) u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .ien_we   (ien_we),
        .ist_we   (ist_we),
        .ctl_we   (ctl_we),
        .ivl_we   (ivl_we),
        .cnt_we   (cnt_we),
        .rd_kind  (rd_kind),
        .rd_ch    (rd_ch)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        itb_channel #(
            .NUM_SRC (NUM_SRC),
            .CNT_W   (CNT_W)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl_we   (ctl_we[c]),
            .ivl_we   (ivl_we[c]),
            .cnt_we   (cnt_we[c]),
            .wval     (bus_wdata),
            .src_tick (src_tick),
            .ctl_q    (ctl_arr[c]),
            .ivl_q    (ivl_arr[c]),
            .cnt_q    (cnt_arr[c]),
            .expire   (exp_w[c]),
            .running  (run_w[c]),
            .oneshot  (mode_w[c])
        );
    end

    itb_irq #(
        .NUM_CH (NUM_CH)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ien_we (ien_we),
        .ist_we (ist_we),
        .wbits  (bus_wdata[NUM_CH-1:0]),
        .expire (exp_w),
        .ien_q  (ien_w),
        .ist_q  (ist_w),
        .irq    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (rd_kind)
            RD_IEN:  bus_rdata = DATA_W'(ien_w);
            RD_IST:  bus_rdata = DATA_W'(ist_w);
            RD_CTL:  bus_rdata = DATA_W'(ctl_arr[rd_ch]);
            RD_IVL:  bus_rdata = ivl_arr[rd_ch];
            RD_CNT:  bus_rdata = cnt_arr[rd_ch];
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/itimer_bank_chk.sv
module itimer_bank_chk #(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NUM_CH-1:0] wbits,
    input logic [NUM_CH-1:0] ien,
    input logic [NUM_CH-1:0] ist,
    input logic [NUM_CH-1:0] expire,
    input logic [NUM_CH-1:0] running,
    input logic [NUM_CH-1:0] oneshot
);

    AST_IEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(0)) |=> (ien == $past(wbits))); // R2

    AST_STATUS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(4)) |=> ((ist & $past(wbits & ~expire)) == '0)); // R3

    AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (expire != '0) |=> ((ist & $past(expire)) == $past(expire))); // R7

    AST_PERIODIC_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        ((expire & ~oneshot) != '0) |=> ((running & $past(expire & ~oneshot)) == $past(expire & ~oneshot))); // R8

    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((expire & oneshot) != '0) |=> ((running & $past(expire & oneshot)) == '0)); // R9

    AST_EXPIRE_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        ((expire & ~running) == '0)); // R6

endmodule

bind itimer_bank itimer_bank_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wbits    (bus_wdata[NUM_CH-1:0]),
    .ien      (ien_w),
    .ist      (ist_w),
    .expire   (exp_w),
    .running  (run_w),
    .oneshot  (mode_w)
);

// File: tb/itimer_bank_tb_top.sv
module itimer_bank_tb_top;

    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_wr = 1'b0;
    logic [9:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [3:0]  b_src = '0;
    logic [31:0] rdata;
    logic [5:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    itimer_bank dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (b_wr),
        .bus_addr  (b_addr),
        .bus_wdata (b_wdata),
        .bus_rdata (rdata),
        .src_tick  (b_src),
        .irq       (irq)
    );

    // Cycle-level reference built from the requirements
    logic [7:0]  m_ctl [NCH];
    logic [31:0] m_ivl [NCH];
    logic [31:0] m_cnt [NCH];
    logic [6:0]  m_ph  [NCH];
    logic [5:0]  m_ien;
    logic [5:0]  m_ist;

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_ctl[c] = 8'h04; m_ivl[c] = '0; m_cnt[c] = '0; m_ph[c] = '0;
        end
        m_ien = '0; m_ist = '0;
    endtask

    task automatic model_step();
        logic [5:0] ex;
        ex = '0;
        for (int c = 0; c < NCH; c++) begin
            logic run, src, tk, cw, iw, nw;
            logic [6:0]  mask;
            logic [31:0] old_ivl;
            run  = m_ctl[c][0];
            src  = b_src[m_ctl[c][3:2]];
            mask = 7'((32'd1 << m_ctl[c][6:4]) - 1);
            tk   = run && src && ((m_ph[c] & mask) == mask);
            cw   = b_wr && (b_addr == 10'(16 * (c + 1)));
            iw   = b_wr && (b_addr == 10'(16 * (c + 1) + 4));
            nw   = b_wr && (b_addr == 10'(16 * (c + 1) + 8));
            old_ivl = m_ivl[c];
            if (cw) m_ph[c] = '0;
            else if (run && src) m_ph[c] = m_ph[c] + 1;
            if (cw) begin
                m_ctl[c] = b_wdata[7:0];
                if (b_wdata[1]) m_cnt[c] = old_ivl;
            end else if (nw) begin
                m_cnt[c] = b_wdata;
            end else if (tk) begin
                if (m_cnt[c] <= 1) begin
                    ex[c] = 1'b1;
                    if (m_ctl[c][7]) begin
                        m_cnt[c] = '0; m_ctl[c][0] = 1'b0;
                    end else begin
                        m_cnt[c] = old_ivl;
                    end
                end else begin
                    m_cnt[c] = m_cnt[c] - 1;
                end
            end
            if (iw) m_ivl[c] = b_wdata;
        end
        if (b_wr && b_addr == 10'h000) m_ien = b_wdata[5:0];
        m_ist = (m_ist & ~((b_wr && b_addr == 10'h004) ? b_wdata[5:0] : 6'h0)) | ex;
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    function automatic logic [31:0] model_read(input logic [9:0] a);
        int w;
        w = int'(a[7:4]);
        if (a[9:8] != 0) return '0;
        if (w == 0) begin
            if (a[3:0] == 4'h0) return 32'(m_ien);
            if (a[3:0] == 4'h4) return 32'(m_ist);
            return '0;
        end
        if (w > NCH) return '0;
        case (a[3:0])
            4'h0:    return 32'(m_ctl[w-1]);
            4'h4:    return m_ivl[w-1];
            4'h8:    return m_cnt[w-1];
            default: return '0;
        endcase
    endfunction

    function automatic string auto_tag(input logic [9:0] a);
        if (a == 10'h000) return "R2";
        if (a == 10'h004) return "R3";
        if (a[9:8] == 0 && a[7:4] >= 1 && a[7:4] <= NCH) begin
            if (a[3:0] == 4'h0) return "R6";
            if (a[3:0] == 4'h8) return "R10";
        end
        return "R11";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h addr=%h t=%0t", tag, act, exp, b_addr, $time);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge
    task automatic cyc(input logic w, input logic [9:0] a, input logic [31:0] d,
                       input logic [3:0] s, input string tag);
        string t;
        b_wr = w; b_addr = a; b_wdata = d; b_src = s;
        @(negedge clk);
        t = (tag == "") ? auto_tag(a) : tag;
        check(t, rdata, model_read(a));
        check("R2", 32'(irq), 32'(m_ist & m_ien));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every mapped register
        cyc(0, 10'h000, 0, 0, "R1");
        cyc(0, 10'h004, 0, 0, "R1");
        for (int c = 0; c < NCH; c++) begin
            cyc(0, 10'(16 * (c + 1)),     0, 0, "R1");
            check("R1", rdata, 32'h04);
            cyc(0, 10'(16 * (c + 1) + 4), 0, 0, "R1");
            cyc(0, 10'(16 * (c + 1) + 8), 0, 0, "R1");
        end
        check("R1", 32'(irq), 0);

        // R11: unmapped offsets read zero and ignore writes
        cyc(1, 10'h070, 32'hFF, 0, "R11");
        cyc(1, 10'h3FC, 32'h1234, 0, "R11");
        cyc(0, 10'h00C, 0, 0, "R11");
        cyc(0, 10'h11C, 0, 0, "R11");

        // R5: reload without enable
        cyc(1, 10'h014, 32'd5, 0, "R11");
        cyc(1, 10'h010, 32'h02, 0, "R5");
        cyc(0, 10'h018, 0, 4'hF, "R5");
        check("R5", rdata, 32'd5);
        cyc(0, 10'h018, 0, 4'hF, "R6");

        // R7/R8: periodic run from source 0, divide-by-1
        cyc(1, 10'h000, 32'h3F, 0, "R2");
        cyc(1, 10'h010, 32'h03, 4'h1, "R6");
        for (int i = 0; i < 14; i++) cyc(0, 10'h018, 0, 4'h1, (i % 2) ? "R8" : "R7");

        // R9: single-shot on channel 1
        cyc(1, 10'h024, 32'd3, 0, "R11");
        cyc(1, 10'h020, 32'h83, 4'h1, "R9");
        for (int i = 0; i < 6; i++) cyc(0, 10'h028, 0, 4'h1, "R9");
        cyc(0, 10'h020, 0, 4'h1, "R9");

        // R4: source 2, divide-by-8
        cyc(1, 10'h034, 32'd100, 0, "R11");
        cyc(1, 10'h030, 32'h3B, 4'h4, "R4");
        for (int i = 0; i < 20; i++) cyc(0, 10'h038, 0, 4'h4, "R4");

        // R3: clear all status bits; R10: count write during ticks
        cyc(1, 10'h004, 32'h3F, 4'h1, "R3");
        cyc(1, 10'h038, 32'd7, 4'h4, "R10");
        cyc(0, 10'h038, 0, 4'h4, "R10");

        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic        w;
            logic [9:0]  a;
            logic [31:0] d;
            int          ch, kind;
            ch   = int'($urandom % NCH);
            kind = int'($urandom % 10);
            case (kind)
                0:       a = 10'h000;
                1:       a = 10'h004;
                2, 3:    a = 10'(16 * (ch + 1));
                4:       a = 10'(16 * (ch + 1) + 4);
                8:       a = 10'($urandom);
                default: a = 10'(16 * (ch + 1) + 8);
            endcase
            w = (($urandom % 6) == 0);
            d = $urandom;
            if (a[3:0] == 4'h0 && a[7:4] != 0) d = {24'h0, d[7], 1'b0, 2'(d[5:4]), d[3:0]};
            else if (a[3:0] != 4'h0 || a[7:4] != 0) d = d % 12;
            cyc(w, a, d, 4'($urandom), "");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule